// File: doc/BRIEF.md
# Serial Register Port with Trickle-Charge Control

This block is the serial slave interface of a timekeeping device's register file. A host talks to it over four wires: an active-low chip select, a serial clock, serial data in, and serial data out with a separate output-enable that marks when the data-out line is driven. All serial inputs are oversampled by the block's own system clock. Each input passes through a two-flop synchronizer, and its edges are detected on the synchronized copy. The design therefore has one clock domain.

Each transaction begins with an address byte. Its most significant bit chooses a write (1) or a read (0), and its lower seven bits give the start address. Every byte after it is written to the register file or read from it. The address advances by one after each data byte, so one chip-select window can carry a burst. The serial clock may idle low or high. The block reads the clock level when chip select falls and keeps that choice until chip select rises again.

One register, at index 0Fh, configures a trickle charger. The block decodes it into one-hot switch enables for two diode paths and three series resistors. The charge path closes only when the register's upper nibble holds the enable key and both selects name a real path.

Top module: `spi_tc_regport`

## Requirements
- R1: While chip select is high, the block ignores serial clock and data activity. No register changes, and `sdo_oe` stays 0.
- R2: When `sclk` is low as chip select falls, the block latches `sdi` on falling `sclk` edges and updates `sdo` on rising edges. This polarity holds until chip select rises.
- R3: When `sclk` is high as chip select falls, the block latches `sdi` on rising `sclk` edges and updates `sdo` on falling edges.
- R4: `sdo_oe` stays 0 throughout the address byte and throughout any write. In a read, it becomes 1 at the launch edge of the first data bit and stays 1 until chip select rises.
- R5: Bits travel MSB first. Bit 7 of the first byte is 1 for a write and 0 for a read, and bits 6:0 are the start address.
- R6: After every data byte, the address increments and wraps from 7Fh to 00h. The register file holds 16 bytes indexed by address bits 3:0, so address 7Fh aliases index 0Fh.
- R7: The trickle-charge register sits at index 0Fh, so it is written with header 8Fh and read with header 0Fh.
- R8: The charger is enabled only when trickle-register bits 7:4 equal 1010b. Any other value opens every switch.
- R9: Bits 3:2 select the diode: 01 gives `diode_en`=01 and 10 gives `diode_en`=10. Bits 1:0 select the resistor: 01 gives `res_en`=001 (about 250 ohm), 10 gives 010 (about 2 kohm), and 11 gives 100 (about 4 kohm). A select of 00, or a diode select of 11, opens all switches even when the key matches. Both outputs are always one-hot or zero, and they are either both zero or both nonzero.
- R10: After reset, every register holds 00h, `sdo_oe` is 0, and all switch enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | 1 while `sdo` should be driven, 0 for high impedance |
| diode_en | output | 2 | One-hot diode path switch enables |
| res_en | output | 3 | One-hot resistor switch enables |

## Verification
The checker watches several invariants on every clock cycle. The output enable must stay low outside a chip-select window, during the address byte and during writes. The captured polarity must not change inside a transaction. `sdo` may change only right after a launch edge. The switch enables must stay one-hot and paired. Only the bench scenarios can show the rest: register contents surviving across transactions, burst increments and the 7Fh wrap, the key and select decoding for each code, and that bus activity with chip select high leaves the stored value untouched. The bench reads values back through the serial port under both clock polarities to observe these.

// File: rtl/spi_tc_pkg.sv
package spi_tc_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] CHG_KEY = 4'b1010;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  typedef struct packed {
    logic [3:0] key;
    logic [1:0] dsel;
    logic [1:0] rsel;
  } tc_cfg_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES + 1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_tc_pkg::*;
#(
  parameter int AW = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_start,
  input  logic              sclk_lvl,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     wr_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              cpol,
  output logic              wr_mode,
  output logic              in_data,
  output logic              launch
);
  localparam int              BIT_W    = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_q, tx_q, rx_next;
  logic [BIT_W-1:0]  bit_q;
  logic [AW-1:0]     addr_q;
  phase_e            phase_q;
  logic              cpol_q, oe_q, sdo_q, wr_mode_q;
  logic              latch, byte_end;

  // leading edge leaves the idle level and launches; trailing edge returns and latches
  assign launch   = cs_active & (cpol_q ? sclk_fall : sclk_rise);
  assign latch    = cs_active & (cpol_q ? sclk_rise : sclk_fall);
  assign rx_next  = {rx_q[BYTE_W-2:0], sdi};
  assign byte_end = latch & (bit_q == BIT_LAST);

  assign rd_addr = (phase_q == PH_ADDR) ? rx_next[AW-1:0] : addr_q + AW'(1);
  assign wr_addr = addr_q;
  assign wr_en   = byte_end & (phase_q == PH_DATA) & wr_mode_q;
  assign wr_data = rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q      <= '0;
      tx_q      <= '0;
      bit_q     <= '0;
      addr_q    <= '0;
      phase_q   <= PH_ADDR;
      cpol_q    <= 1'b0;
      oe_q      <= 1'b0;
      sdo_q     <= 1'b0;
      wr_mode_q <= 1'b0;
    end else begin
      if (cs_start) cpol_q <= sclk_lvl;
      if (!cs_active) begin
        bit_q     <= '0;
        phase_q   <= PH_ADDR;
        oe_q      <= 1'b0;
        wr_mode_q <= 1'b0;
      end else if (latch) begin
        rx_q  <= rx_next;
        bit_q <= bit_q + BIT_W'(1);
        if (byte_end) begin
          if (phase_q == PH_ADDR) begin
            addr_q    <= rx_next[AW-1:0];
            wr_mode_q <= rx_next[BYTE_W-1];
            phase_q   <= PH_DATA;
          end else begin
            addr_q <= addr_q + AW'(1);
          end
          tx_q <= rd_data;
        end
      end else if (launch && phase_q == PH_DATA && !wr_mode_q) begin
        sdo_q <= tx_q[BYTE_W-1];
        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        oe_q  <= 1'b1;
      end
    end
  end

  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;
  assign cpol    = cpol_q;
  assign wr_mode = wr_mode_q;
  assign in_data = (phase_q == PH_DATA);
endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store
  import spi_tc_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TC_IDX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] tc_value
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_idx];
  assign tc_value = mem[TC_IDX];
endmodule

// File: rtl/tc_charge_decode.sv
module tc_charge_decode
  import spi_tc_pkg::*;
#(
  parameter int N_DIODE = 2,
  parameter int N_RES   = 3
) (
  input  tc_cfg_t            cfg,
  output logic [N_DIODE-1:0] diode_en,
  output logic [N_RES-1:0]   res_en
);
  logic key_ok, ds_ok, rs_ok, path_on;

  assign key_ok  = (cfg.key == CHG_KEY);
  assign ds_ok   = (cfg.dsel != 2'd0) && (cfg.dsel <= 2'(N_DIODE));
  assign rs_ok   = (cfg.rsel != 2'd0) && (cfg.rsel <= 2'(N_RES));
  assign path_on = key_ok & ds_ok & rs_ok;

  for (genvar d = 0; d < N_DIODE; d++) begin : g_diode
    assign diode_en[d] = path_on & (cfg.dsel == 2'(d + 1));
  end

  for (genvar r = 0; r < N_RES; r++) begin : g_res
    assign res_en[r] = path_on & (cfg.rsel == 2'(r + 1));
  end
endmodule

// File: rtl/spi_tc_regport.sv
module spi_tc_regport
  import spi_tc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 4,
  parameter int TC_IDX      = 15,
  parameter int N_DIODE     = 2,
  parameter int N_RES       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [N_DIODE-1:0] diode_en,
  output logic [N_RES-1:0]   res_en
);
  localparam int AW = BYTE_W - 1;

  logic cs_lvl, cs_rise_unused, cs_start;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic sdi_lvl, sdi_rise_unused, sdi_fall_unused;
  logic cs_active;

  logic [AW-1:0]     rd_addr, wr_addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data, tc_value;
  logic              cpol, wr_mode, in_data, launch;

  spi_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .din(cs_n),
    .lvl(cs_lvl), .rise(cs_rise_unused), .fall(cs_start)
  );

  spi_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk),
    .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  spi_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .din(sdi),
    .lvl(sdi_lvl), .rise(sdi_rise_unused), .fall(sdi_fall_unused)
  );

  assign cs_active = ~cs_lvl;

  spi_frame_engine #(.AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .cs_active(cs_active), .cs_start(cs_start),
    .sclk_lvl(sclk_lvl), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sdi(sdi_lvl), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_en(wr_en), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .cpol(cpol), .wr_mode(wr_mode),
    .in_data(in_data), .launch(launch)
  );

  spi_reg_store #(.IDX_W(IDX_W), .TC_IDX(TC_IDX)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_addr[IDX_W-1:0]), .wr_data(wr_data),
    .rd_idx(rd_addr[IDX_W-1:0]), .rd_data(rd_data),
    .tc_value(tc_value)
  );

  tc_charge_decode #(.N_DIODE(N_DIODE), .N_RES(N_RES)) u_decode (
    .cfg(tc_cfg_t'(tc_value)),
    .diode_en(diode_en),
    .res_en(res_en)
  );
endmodule

// File: rtl/spi_tc_regport_chk.sv
module spi_tc_regport_chk #(
  parameter int N_DIODE = 2,
  parameter int N_RES   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_active,
  input logic               sdo,
  input logic               sdo_oe,
  input logic               launch,
  input logic               cpol,
  input logic               wr_mode,
  input logic               in_data,
  input logic [N_DIODE-1:0] diode_en,
  input logic [N_RES-1:0]   res_en
);
  assert_hiz_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_active && !$past(cs_active)) |-> !sdo_oe);

  assert_no_drive_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |-> !sdo_oe);

  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |-> !sdo_oe);

  assert_cpol_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && $past(cs_active) && $past(cs_active, 2)) |-> $stable(cpol));

  assert_sdo_on_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(launch));

  assert_switch_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(diode_en) && $onehot0(res_en));

  assert_switch_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|diode_en) == (|res_en));
endmodule

bind spi_tc_regport spi_tc_regport_chk #(.N_DIODE(N_DIODE), .N_RES(N_RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
  .sdo(sdo), .sdo_oe(sdo_oe), .launch(launch), .cpol(cpol),
  .wr_mode(wr_mode), .in_data(in_data),
  .diode_en(diode_en), .res_en(res_en)
);

// File: tb/test_spi_tc_regport.sv
module test_spi_tc_regport;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  logic sdo, sdo_oe;
  logic [1:0] diode_en;
  logic [2:0] res_en;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] wbuf [0:7];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mon_byte;
  event       mon_evt;

  always #5 clk = ~clk;

  spi_tc_regport i_spi_tc_regport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .diode_en(diode_en), .res_en(res_en)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] val);
    exp_q.push_back(val);
    tag_q.push_back(tag);
  endtask

  // monitor: compares every byte the master collects against the scoreboard
  initial begin
    forever begin
      @(mon_evt);
      if (exp_q.size() == 0) begin
        chk("R5 unexpected read byte", {24'd0, mon_byte}, 32'hFFFF_FFFF);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {24'd0, mon_byte}, {24'd0, e});
      end
    end
  end

  // driver: one chip-select window, header plus n data bytes, MSB first
  task automatic spi_txn(input bit pol, input bit hold_cs, input logic [7:0] hdr, input int n);
    automatic bit rd = !hdr[7] && !hold_cs;
    automatic bit oe_bad = 1'b0;
    logic [7:0] cur, rx;
    sclk = pol;
    half();
    cs_n = hold_cs;
    half();
    for (int b = 0; b <= n; b++) begin
      cur = (b == 0) ? hdr : (rd ? 8'h00 : wbuf[b-1]);
      rx  = 8'h00;
      for (int i = 7; i >= 0; i--) begin
        sclk = ~pol;
        sdi  = cur[i];
        half();
        if (rd && b > 0) begin
          rx[i] = sdo;
          if (!sdo_oe) oe_bad = 1'b1;
        end else if (sdo_oe) begin
          oe_bad = 1'b1;
        end
        sclk = pol;
        half();
      end
      if (rd && b > 0) begin
        mon_byte = rx;
        -> mon_evt;
      end
    end
    half();
    cs_n = 1'b1;
    sdi  = 1'b0;
    half();
    half();
    chk(hold_cs ? "R1 output enable with chip select high" : "R4 output enable window",
        {31'd0, oe_bad}, 32'd0);
  endtask

  task automatic wr_tc(input bit pol, input logic [7:0] val);
    wbuf[0] = val;
    spi_txn(pol, 1'b0, 8'h8F, 1);
  endtask

  task automatic chk_sw(input string tag, input logic [1:0] d, input logic [2:0] r);
    chk({tag, " diode_en"}, {30'd0, diode_en}, {30'd0, d});
    chk({tag, " res_en"}, {29'd0, res_en}, {29'd0, r});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    sdi   = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    half();

    // R10: reset state
    chk("R10 sdo_oe after reset", {31'd0, sdo_oe}, 32'd0);
    chk_sw("R10 switches after reset", 2'b00, 3'b000);

    // R7 R5: trickle register reads 00h after reset, idle-low clock
    expect_rd("R7 trickle reset value", 8'h00);
    spi_txn(1'b0, 1'b0, 8'h0F, 1);

    // R2 R8 R9: write A5h with idle-low clock, key matches, diode 01 resistor 01
    wr_tc(1'b0, 8'hA5);
    chk_sw("R2 R8 A5h", 2'b01, 3'b001);

    // R3: read back with idle-high clock
    expect_rd("R3 idle-high read of A5h", 8'hA5);
    spi_txn(1'b1, 1'b0, 8'h0F, 1);

    // R8: wrong key opens everything
    wr_tc(1'b1, 8'h55);
    chk_sw("R8 key 0101b", 2'b00, 3'b000);

    // R9: diode 10, resistor 11
    wr_tc(1'b1, 8'hAB);
    chk_sw("R9 ABh", 2'b10, 3'b100);
    wr_tc(1'b0, 8'hAA);
    chk_sw("R9 AAh", 2'b10, 3'b010);

    // R9: invalid selects
    wr_tc(1'b0, 8'hA1);
    chk_sw("R9 diode select 00", 2'b00, 3'b000);
    wr_tc(1'b0, 8'hA4);
    chk_sw("R9 resistor select 00", 2'b00, 3'b000);
    wr_tc(1'b1, 8'hAD);
    chk_sw("R9 diode select 11", 2'b00, 3'b000);

    // R1: bus activity with chip select high is ignored
    wr_tc(1'b0, 8'hA5);
    wbuf[0] = 8'h00;
    spi_txn(1'b0, 1'b1, 8'h8F, 1);
    chk_sw("R1 switches unchanged", 2'b01, 3'b001);
    expect_rd("R1 register unchanged", 8'hA5);
    spi_txn(1'b1, 1'b0, 8'h0F, 1);

    // R6: burst write with idle-high clock, burst read with idle-low clock
    wbuf[0] = 8'h11;
    wbuf[1] = 8'h22;
    wbuf[2] = 8'h33;
    spi_txn(1'b1, 1'b0, 8'h83, 3);
    expect_rd("R6 burst byte 0", 8'h11);
    expect_rd("R6 burst byte 1", 8'h22);
    expect_rd("R6 burst byte 2", 8'h33);
    spi_txn(1'b0, 1'b0, 8'h03, 3);

    // R6: wrap from 7Fh to 00h, 7Fh aliases index 0Fh
    wbuf[0] = 8'hA9;
    wbuf[1] = 8'h77;
    spi_txn(1'b0, 1'b0, 8'hFF, 2);
    chk_sw("R6 R7 alias write A9h", 2'b10, 3'b001);
    expect_rd("R6 wrapped byte at 00h", 8'h77);
    spi_txn(1'b1, 1'b0, 8'h00, 1);
    expect_rd("R6 R7 read via 0Fh", 8'hA9);
    expect_rd("R6 continue to 10h alias 00h", 8'h77);
    spi_txn(1'b0, 1'b0, 8'h0F, 2);

    half();
    chk("R5 scoreboard drained", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule